// File: doc/BRIEF.md
# Set-Associative Branch Target Entry Store

This block is the storage behind a branch target predictor. It holds tagged, opaque entry payloads in a set-associative array. A fetch address picks the set and supplies the tag. All ways of that set are compared at once, and the block returns the matching payload together with the number of the way that matched.

Two read sources share one lookup. The first is the prediction read, which uses a valid/ready handshake. The second is the update read, used by training logic to find out whether an address is already present. The update read always wins, and the prediction source is held off while it is served. In both cases the answer appears on the cycle after acceptance.

A single write port stores a payload in one of two ways. It either writes to a named way, or it allocates a way itself. Allocation takes the lowest-numbered empty way of the set, and only when the set is full does it replace the victim chosen by a per-set tree pseudo-LRU state.

Top module: `tagged_entry_store`

## Requirements
- R1: An address is split as follows. Bits [OFS_W-1:0] are the instruction offset and play no part in the lookup. The next IDX_W = log2(SETS) bits select the set. The TAG_W bits above those form the tag, which is stored with each entry. With the defaults this means set = pc[9:1] and tag = pc[29:10]. Two addresses that differ only in the offset bits reach the same entry.
- R2: A read accepted in cycle t presents its result during cycle t+1. A hit asserts the hit flag of the source that made the request, gives the matching way number, and drives that way's payload on `rd_data`. In a cycle that follows no accepted request from a source, that source's hit flag is low.
- R3: A lookup whose tag matches no valid way in the set drives the requesting source's hit flag low. After reset every way of every set is empty, so every lookup misses.
- R4: The update read takes priority when both sources request in the same cycle. `pred_ready` is low in any cycle where `upd_valid` is high. A prediction request made in that cycle gets no response.
- R5: When `wr_valid` is high and `wr_alloc` is low, the entry (tag and payload) is written into way `wr_way` of the addressed set, and that way is marked valid. The entry that way held before is lost.
- R6: When `wr_valid` and `wr_alloc` are both high, `wr_way` is ignored, and the entry goes to the lowest-numbered way of the set whose valid bit is clear.
- R7: When allocating into a set with no empty way, the victim comes from the set's tree state. With 4 ways the state has 3 bits:
  - Bit 0 chooses the half: 0 selects ways 0 to 1, and 1 selects ways 2 to 3.
  - Bit 1 chooses within ways 0 to 1 (0 gives way 0).
  - Bit 2 chooses within ways 2 to 3 (0 gives way 2).
  - The tree state of every set is zero after reset.
- R8: Every prediction-read hit and every write updates the tree bits along the path to the touched way so that they point away from it. Update reads and misses leave the tree unchanged.
- R9: A write in cycle t is visible to a read accepted in the same cycle t, whose result appears in cycle t+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_valid | input | 1 | Prediction read request |
| pred_ready | output | 1 | Prediction read can be accepted this cycle |
| pred_pc | input | PC_W | Prediction read address |
| upd_valid | input | 1 | Update read request (always accepted) |
| upd_pc | input | PC_W | Update read address |
| wr_valid | input | 1 | Write request |
| wr_pc | input | PC_W | Write address (set and tag) |
| wr_data | input | DATA_W | Entry payload to store |
| wr_way | input | log2(WAYS) | Target way for a non-allocating write |
| wr_alloc | input | 1 | Let the block choose the way (empty first, else pseudo-LRU) |
| rd_data | output | DATA_W | Payload of the hit way, one cycle after the request |
| pred_hit_valid | output | 1 | Prediction read hit |
| pred_hit_way | output | log2(WAYS) | Way matched by the prediction read |
| upd_hit_valid | output | 1 | Update read hit |
| upd_hit_way | output | log2(WAYS) | Way matched by the update read |

## Verification
The bench builds the store with SETS=4, WAYS=4, TAG_W=4, DATA_W=8, PC_W=8 and OFS_W=1. This keeps the whole array small enough to fill every set completely and to drive each set through several rounds of full-set replacement. In the process the bench touches every branch of the three-bit victim tree and checks every evicted tag. A bench model computes the expected empty-first choice, the tree victim and the tree updates from the bit rules in R6 to R8. The reduced tag width also makes it cheap to collide requests on purpose: the bench issues both reads in one cycle, and it writes and reads the same address in one cycle.

// File: rtl/tes_pkg.sv
package tes_pkg;

    // Which source the registered lookup belongs to.
    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_PRED = 2'd1,
        RD_UPD  = 2'd2
    } rd_src_e;

    // Deepest supported tree (64 ways).
    localparam int MAX_LVLS = 6;

    // Tree pseudo-LRU state is heap ordered: node n (1-based) keeps its
    // bit at position n-1, and its children are 2n (bit 0) and 2n+1 (bit 1).
    // A bit value of 0 sends the victim walk to the lower-numbered half.
    function automatic logic [63:0] plru_touch(logic [63:0] st, logic [5:0] way, int lvls);
        logic [6:0] nd;
        logic       b;
        int         sh;
        nd = 7'd1;
        for (int l = 0; l < MAX_LVLS; l++) begin
            if (l < lvls) begin
                sh = lvls - 1 - l;
                b  = way[sh[2:0]];
                st[6'(nd - 7'd1)] = ~b;
                nd = {nd[5:0], b};
            end
        end
        return st;
    endfunction

    function automatic logic [5:0] plru_victim(logic [63:0] st, int lvls);
        logic [6:0] nd;
        logic       b;
        nd = 7'd1;
        for (int l = 0; l < MAX_LVLS; l++) begin
            if (l < lvls) begin
                b  = st[6'(nd - 7'd1)];
                nd = {nd[5:0], b};
            end
        end
        return 6'(nd - (7'd1 << lvls));
    endfunction

endpackage

// File: rtl/tes_way_match.sv
module tes_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 20,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            way_vld,
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [TAG_W-1:0]           req_tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);

    logic [WAYS-1:0] eq;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign eq[w] = way_vld[w] && (way_tag[w] == req_tag);
    end

    // Lowest matching way wins should duplicates ever exist.
    always_comb begin
        hit     = |eq;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (eq[w]) hit_way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/tes_victim_pick.sv
module tes_victim_pick
    import tes_pkg::*;
#(
    parameter int WAYS = 4,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int PLRU_W = WAYS - 1
) (
    input  logic [WAYS-1:0]   way_vld,
    input  logic [PLRU_W-1:0] tree_st,
    input  logic              alloc,
    input  logic [WAY_W-1:0]  req_way,
    output logic [WAY_W-1:0]  pick_way
);

    logic             any_empty;
    logic [WAY_W-1:0] empty_way;
    logic [WAY_W-1:0] tree_way;

    always_comb begin
        any_empty = ~&way_vld;
        empty_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_vld[w]) empty_way = WAY_W'(w);
        end
        tree_way = WAY_W'(plru_victim(64'(tree_st), WAY_W));
        if (!alloc)         pick_way = req_way;
        else if (any_empty) pick_way = empty_way;
        else                pick_way = tree_way;
    end

endmodule

// File: rtl/tes_plru_bank.sv
module tes_plru_bank
    import tes_pkg::*;
#(
    parameter int SETS = 512,
    parameter int WAYS = 4,
    localparam int IDX_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int PLRU_W = WAYS - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit_en,
    input  logic [IDX_W-1:0]  hit_idx,
    input  logic [WAY_W-1:0]  hit_way,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WAY_W-1:0]  wr_way,
    output logic [PLRU_W-1:0] wr_set_st
);

    logic [PLRU_W-1:0] st [SETS];
    logic [PLRU_W-1:0] st_after_hit;
    logic [PLRU_W-1:0] st_wr_base;
    logic [PLRU_W-1:0] st_after_wr;

    assign wr_set_st = st[wr_idx];

    // A hit touch and a write touch on the same set compose in order.
    always_comb begin
        st_after_hit = PLRU_W'(plru_touch(64'(st[hit_idx]), 6'(hit_way), WAY_W));
        st_wr_base   = (hit_en && (hit_idx == wr_idx)) ? st_after_hit : st[wr_idx];
        st_after_wr  = PLRU_W'(plru_touch(64'(st_wr_base), 6'(wr_way), WAY_W));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) st[s] <= '0;
        end else begin
            if (hit_en) st[hit_idx] <= st_after_hit;
            if (wr_en)  st[wr_idx]  <= st_after_wr;
        end
    end

endmodule

// File: rtl/tagged_entry_store.sv
module tagged_entry_store
    import tes_pkg::*;
#(
    parameter int SETS   = 512,
    parameter int WAYS   = 4,
    parameter int TAG_W  = 20,
    parameter int DATA_W = 64,
    parameter int OFS_W  = 1,
    parameter int PC_W   = 41,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pred_valid,
    output logic              pred_ready,
    input  logic [PC_W-1:0]   pred_pc,
    input  logic              upd_valid,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic              wr_valid,
    input  logic [PC_W-1:0]   wr_pc,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic              wr_alloc,
    output logic [DATA_W-1:0] rd_data,
    output logic              pred_hit_valid,
    output logic [WAY_W-1:0]  pred_hit_way,
    output logic              upd_hit_valid,
    output logic [WAY_W-1:0]  upd_hit_way
);

    localparam int IDX_W   = $clog2(SETS);
    localparam int PLRU_W  = WAYS - 1;
    localparam int IDX_LSB = OFS_W;
    localparam int TAG_LSB = OFS_W + IDX_W;

    // Storage: valid bits (reset), tags and payloads (no reset).
    logic [WAYS-1:0]              vld_mem  [SETS];
    logic [WAYS-1:0][TAG_W-1:0]   tag_mem  [SETS];
    logic [WAYS-1:0][DATA_W-1:0]  data_mem [SETS];

    // Read arbitration: update read first.
    rd_src_e           src_q;
    logic [IDX_W-1:0]  req_idx_q;
    logic [TAG_W-1:0]  req_tag_q;
    logic [PC_W-1:0]   sel_pc;
    logic              unused_pc_bits;

    assign pred_ready     = !upd_valid;
    assign sel_pc         = upd_valid ? upd_pc : pred_pc;
    assign unused_pc_bits = ^{pred_pc, upd_pc, wr_pc};

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q     <= RD_IDLE;
            req_idx_q <= '0;
            req_tag_q <= '0;
        end else begin
            if (upd_valid)       src_q <= RD_UPD;
            else if (pred_valid) src_q <= RD_PRED;
            else                 src_q <= RD_IDLE;
            req_idx_q <= sel_pc[IDX_LSB +: IDX_W];
            req_tag_q <= sel_pc[TAG_LSB +: TAG_W];
        end
    end

    // Lookup against the captured set.
    logic             lk_hit;
    logic [WAY_W-1:0] lk_way;

    tes_way_match #(
        .WAYS  (WAYS),
        .TAG_W (TAG_W)
    ) u_match (
        .way_vld (vld_mem[req_idx_q]),
        .way_tag (tag_mem[req_idx_q]),
        .req_tag (req_tag_q),
        .hit     (lk_hit),
        .hit_way (lk_way)
    );

    assign rd_data        = data_mem[req_idx_q][lk_way];
    assign pred_hit_valid = (src_q == RD_PRED) && lk_hit;
    assign upd_hit_valid  = (src_q == RD_UPD) && lk_hit;
    assign pred_hit_way   = lk_way;
    assign upd_hit_way    = lk_way;

    // Write path: way selection.
    logic [IDX_W-1:0]  wr_idx;
    logic [TAG_W-1:0]  wr_tag;
    logic [PLRU_W-1:0] wr_tree;
    logic [WAY_W-1:0]  wr_way_sel;

    assign wr_idx = wr_pc[IDX_LSB +: IDX_W];
    assign wr_tag = wr_pc[TAG_LSB +: TAG_W];

    tes_victim_pick #(
        .WAYS (WAYS)
    ) u_pick (
        .way_vld  (vld_mem[wr_idx]),
        .tree_st  (wr_tree),
        .alloc    (wr_alloc),
        .req_way  (wr_way),
        .pick_way (wr_way_sel)
    );

    tes_plru_bank #(
        .SETS (SETS),
        .WAYS (WAYS)
    ) u_plru (
        .clk       (clk),
        .rst       (rst),
        .hit_en    (pred_hit_valid),
        .hit_idx   (req_idx_q),
        .hit_way   (lk_way),
        .wr_en     (wr_valid),
        .wr_idx    (wr_idx),
        .wr_way    (wr_way_sel),
        .wr_set_st (wr_tree)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) vld_mem[s] <= '0;
        end else if (wr_valid) begin
            vld_mem[wr_idx][wr_way_sel] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_valid) begin
            tag_mem[wr_idx][wr_way_sel]  <= wr_tag;
            data_mem[wr_idx][wr_way_sel] <= wr_data;
        end
    end

endmodule

// File: rtl/tes_checker.sv
module tes_checker #(
    parameter int PC_W = 41
) (
    input logic            clk,
    input logic            rst,
    input logic            pred_valid,
    input logic            pred_ready,
    input logic [PC_W-1:0] pred_pc,
    input logic            upd_valid,
    input logic [PC_W-1:0] upd_pc,
    input logic            wr_valid,
    input logic [PC_W-1:0] wr_pc,
    input logic            pred_hit_valid,
    input logic            upd_hit_valid
);

    logic unused_chk;
    assign unused_chk = ^pred_pc;

    // R4: a prediction request colliding with an update read gets no answer.
    p_collide_drop_r4: assert property (@(posedge clk) disable iff (rst)
        (pred_valid && upd_valid) |=> !pred_hit_valid);

    // R2: no accepted prediction request, no prediction hit next cycle.
    p_pred_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !(pred_valid && pred_ready) |=> !pred_hit_valid);

    // R2: no update request, no update hit next cycle.
    p_upd_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> !upd_hit_valid);

    // R9: a write is seen by an update read of the same address in the same cycle.
    p_write_seen_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && upd_valid && (wr_pc == upd_pc)) |=> upd_hit_valid);

    // R2: one lookup serves one source at a time.
    p_one_source_r2: assert property (@(posedge clk) disable iff (rst)
        !(pred_hit_valid && upd_hit_valid));

endmodule

bind tagged_entry_store tes_checker #(.PC_W(PC_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .pred_valid     (pred_valid),
    .pred_ready     (pred_ready),
    .pred_pc        (pred_pc),
    .upd_valid      (upd_valid),
    .upd_pc         (upd_pc),
    .wr_valid       (wr_valid),
    .wr_pc          (wr_pc),
    .pred_hit_valid (pred_hit_valid),
    .upd_hit_valid  (upd_hit_valid)
);

// File: tb/tagged_entry_store_tb_top.sv
module tagged_entry_store_tb_top;

    localparam int SETS = 4;
    localparam int WAYS = 4;
    localparam int TAG_W = 4;
    localparam int DATA_W = 8;
    localparam int OFS_W = 1;
    localparam int PC_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pred_valid = 1'b0, upd_valid = 1'b0, wr_valid = 1'b0, wr_alloc = 1'b0;
    logic [PC_W-1:0] pred_pc = '0, upd_pc = '0, wr_pc = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [1:0] wr_way = '0;
    logic pred_ready, pred_hit_valid, upd_hit_valid;
    logic [1:0] pred_hit_way, upd_hit_way;
    logic [DATA_W-1:0] rd_data;

    always #5 clk = ~clk;

    tagged_entry_store #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W),
        .OFS_W(OFS_W), .PC_W(PC_W)
    ) dut_i (
        .clk(clk), .rst(rst),
        .pred_valid(pred_valid), .pred_ready(pred_ready), .pred_pc(pred_pc),
        .upd_valid(upd_valid), .upd_pc(upd_pc),
        .wr_valid(wr_valid), .wr_pc(wr_pc), .wr_data(wr_data),
        .wr_way(wr_way), .wr_alloc(wr_alloc),
        .rd_data(rd_data),
        .pred_hit_valid(pred_hit_valid), .pred_hit_way(pred_hit_way),
        .upd_hit_valid(upd_hit_valid), .upd_hit_way(upd_hit_way)
    );

    int checks = 0;
    int failures = 0;

    // Bench model of the array.
    bit       mv [SETS][WAYS];
    int       mt [SETS][WAYS];
    bit [2:0] mp [SETS];

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [PC_W-1:0] mkpc(int tag, int set, bit ofs);
        return {1'b0, 4'(tag), 2'(set), ofs};
    endfunction

    function automatic logic [7:0] mkdata(int tag, int set, int salt);
        return 8'((tag * 16 + set * 4 + salt) ^ 8'h5A);
    endfunction

    function automatic int m_victim(int s);
        if (mp[s][0] == 1'b0) return mp[s][1] ? 1 : 0;
        return mp[s][2] ? 3 : 2;
    endfunction

    task automatic m_touch(int s, int w);
        if (w < 2) begin
            mp[s][0] = 1'b1;
            mp[s][1] = (w == 0);
        end else begin
            mp[s][0] = 1'b0;
            mp[s][2] = (w == 2);
        end
    endtask

    task automatic m_lookup(int s, int tag, output bit hit, output int way);
        hit = 0;
        way = 0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (mv[s][w] && mt[s][w] == tag) begin
                hit = 1;
                way = w;
            end
        end
    endtask

    // Model the effect of a write, return the way it lands in.
    task automatic m_write(int s, int tag, int way, bit alloc, output int used);
        int empty;
        empty = -1;
        for (int w = WAYS - 1; w >= 0; w--) if (!mv[s][w]) empty = w;
        if (!alloc) used = way;
        else if (empty >= 0) used = empty;
        else used = m_victim(s);
        mv[s][used] = 1;
        mt[s][used] = tag;
        m_touch(s, used);
    endtask

    task automatic do_write(int s, int tag, int way, bit alloc, int salt, output int used);
        m_write(s, tag, way, alloc, used);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_pc    = mkpc(tag, s, 1'b0);
        wr_data  = mkdata(tag, s, salt);
        wr_way   = 2'(way);
        wr_alloc = alloc;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic do_read(bit use_upd, int s, int tag, bit ofs,
                           output bit hv, output int hw, output int dat);
        @(negedge clk);
        if (use_upd) begin
            upd_valid = 1'b1;
            upd_pc    = mkpc(tag, s, ofs);
        end else begin
            pred_valid = 1'b1;
            pred_pc    = mkpc(tag, s, ofs);
        end
        @(negedge clk);
        upd_valid  = 1'b0;
        pred_valid = 1'b0;
        hv  = use_upd ? upd_hit_valid : pred_hit_valid;
        hw  = use_upd ? int'(upd_hit_way) : int'(pred_hit_way);
        dat = int'(rd_data);
        if (!use_upd && hv) m_touch(s, hw);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit hv, mhit;
        int hw, dat, used, mway, evict, exp_way;

        for (int s = 0; s < SETS; s++) begin
            mp[s] = '0;
            for (int w = 0; w < WAYS; w++) begin
                mv[s][w] = 0;
                mt[s][w] = 0;
            end
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R4 pred_ready idle", int'(pred_ready), 1);

        // R3: empty after reset, every set misses.
        for (int s = 0; s < SETS; s++) begin
            do_read(1'b0, s, 5, 1'b0, hv, hw, dat);
            check("R3 miss after reset", int'(hv), 0);
        end

        // R6, R2, R1: fill each set by allocation, requested way ignored.
        for (int s = 0; s < SETS; s++) begin
            for (int k = 0; k < WAYS; k++) begin
                do_write(s, k + 1, 3 - k, 1'b1, 0, used);
                check("R6 empty-first model way", used, k);
                do_read(1'b1, s, k + 1, 1'b0, hv, hw, dat);
                check("R6 upd hit", int'(hv), 1);
                check("R6 hit way lowest empty", hw, k);
                do_read(1'b0, s, k + 1, 1'b1, hv, hw, dat);
                check("R1 offset ignored hit", int'(hv), 1);
                check("R2 pred hit way", hw, k);
                check("R2 payload", dat, int'(mkdata(k + 1, s, 0)));
            end
        end

        // R7, R8: full-set replacement driven by the tree.
        for (int s = 0; s < SETS; s++) begin
            for (int r = 0; r < 3; r++) begin
                m_lookup(s, mt[s][(r + s) % WAYS], mhit, mway);
                do_read(1'b0, s, mt[s][(r + s) % WAYS], 1'b0, hv, hw, dat);
                check("R8 touch read hit", int'(hv), 1);
                check("R8 touch read way", hw, mway);
                exp_way = m_victim(s);
                evict   = mt[s][exp_way];
                do_write(s, 8 + r, 0, 1'b1, 1, used);
                check("R7 model victim", used, exp_way);
                do_read(1'b1, s, 8 + r, 1'b0, hv, hw, dat);
                check("R7 new entry hit", int'(hv), 1);
                check("R7 new entry in victim way", hw, exp_way);
                check("R7 new payload", dat, int'(mkdata(8 + r, s, 1)));
                do_read(1'b1, s, evict, 1'b0, hv, hw, dat);
                check("R7 evicted tag misses", int'(hv), 0);
            end
        end

        // R5: direct write to a named way.
        evict = mt[1][2];
        do_write(1, 13, 2, 1'b0, 2, used);
        do_read(1'b1, 1, 13, 1'b0, hv, hw, dat);
        check("R5 direct write hit", int'(hv), 1);
        check("R5 direct write way", hw, 2);
        check("R5 direct write payload", dat, int'(mkdata(13, 1, 2)));
        do_read(1'b1, 1, evict, 1'b0, hv, hw, dat);
        check("R5 overwritten tag misses", int'(hv), 0);

        // R3: absent tag misses on a full set.
        do_read(1'b0, 3, 15, 1'b0, hv, hw, dat);
        check("R3 absent tag", int'(hv), 0);

        // R4: both sources in one cycle.
        m_lookup(0, mt[0][1], mhit, mway);
        @(negedge clk);
        upd_valid  = 1'b1;
        upd_pc     = mkpc(mt[0][1], 0, 1'b0);
        pred_valid = 1'b1;
        pred_pc    = mkpc(mt[2][0], 2, 1'b0);
        #1;
        check("R4 pred_ready low during upd", int'(pred_ready), 0);
        @(negedge clk);
        upd_valid  = 1'b0;
        pred_valid = 1'b0;
        check("R4 upd served", int'(upd_hit_valid), 1);
        check("R4 upd way", int'(upd_hit_way), mway);
        check("R4 pred dropped", int'(pred_hit_valid), 0);

        // R9: write and update read of the same address in one cycle.
        m_write(2, 14, 0, 1'b1, used);
        @(negedge clk);
        wr_valid  = 1'b1;
        wr_pc     = mkpc(14, 2, 1'b0);
        wr_data   = mkdata(14, 2, 3);
        wr_way    = 2'd0;
        wr_alloc  = 1'b1;
        upd_valid = 1'b1;
        upd_pc    = mkpc(14, 2, 1'b0);
        @(negedge clk);
        wr_valid  = 1'b0;
        upd_valid = 1'b0;
        check("R9 same-cycle hit", int'(upd_hit_valid), 1);
        check("R9 same-cycle way", int'(upd_hit_way), used);
        check("R9 same-cycle payload", int'(rd_data), int'(mkdata(14, 2, 3)));

        // R2: idle cycle shows no hit on either source.
        @(negedge clk);
        check("R2 idle pred", int'(pred_hit_valid), 0);
        check("R2 idle upd", int'(upd_hit_valid), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule